// File: doc/BRIEF.md
# Light-Load Standby Event Manager

This block decides when a switched-mode converter controller drops into a low-power standby state and when it leaves it. It also drives the enable of a switch that feeds bias power to an auxiliary supply, such as a front-end power-factor stage. The block works only from single-bit comparator results. One flag says the feedback is below the skip threshold (a quarter of the maximum peak-current setpoint). One says the feedback is still below the standby-exit threshold. The third is the maximum-current error flag. All three enter asynchronously and pass through two-flop synchronizers before any edge is detected.

Entry into standby is slow and exit is fast. A rising edge of the below-skip flag starts a long confirmation timer. The auxiliary switch opens only if the low-load condition is still present when that timer expires. A falling edge of the below-exit flag, meaning feedback has climbed past the exit threshold, closes the switch on the next clock edge. Feedback ripple around the skip threshold leaves standby untouched. During startup the switch stays open until the error flag has risen and dropped again before its own timeout. An error flag that outlasts the timeout holds the switch open until the flag clears. The timeout is a parameter in clock ticks, so a simulation can use a short value.

Top module: `standby_event_mgr`

## Requirements
- R1: `skip_req` equals the level of `fb_below_skip` delayed by exactly two clock edges (two-flop synchronizer). It is 0 while `rst` is held.
- R2: In the cycle after a synchronous reset, `aux_en`, `standby` and `skip_req` are all 0.
- R3: After reset, `aux_en` stays 0 until `err_imax` has risen and fallen. If it falls before `CONFIRM_TICKS` ticks have elapsed, `aux_en` becomes 1 three clock edges after the raw input falls.
- R4: If `err_imax` stays high through the whole confirmation window during startup, `aux_en` stays 0. It becomes 1 once the flag falls.
- R5: While running, a rise of `fb_below_skip` starts a `CONFIRM_TICKS` timer. Let the raw input be high from edge 1 to edge d. Then `standby` becomes 1 (and `aux_en` 0) exactly when d >= `CONFIRM_TICKS`+2.
- R6: If `fb_below_skip` is gone when the confirmation timer expires, the block stays running with `aux_en` = 1 and `standby` = 0.
- R7: While in standby, toggling `fb_below_skip` with `fb_below_exit` held high has no effect: `standby` stays 1 and `aux_en` stays 0.
- R8: In standby, a falling edge of `fb_below_exit` leaves standby with no timer. `aux_en` is 0 two edges after the raw input falls and 1 after the third edge.
- R9: While running or in standby, an `err_imax` level that persists through the confirmation window sets `aux_en` to 0. The next fall of the flag sets it back to 1.
- R10: The confirmation length is the parameter `CONFIRM_TICKS` in clock ticks. The counter never reaches `CONFIRM_TICKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_below_skip | input | 1 | Asynchronous flag: feedback below the skip threshold |
| fb_below_exit | input | 1 | Asynchronous flag: feedback below the standby-exit threshold |
| err_imax | input | 1 | Asynchronous maximum-current error flag |
| skip_req | output | 1 | Request to blank switching pulses |
| aux_en | output | 1 | Enable for the auxiliary bias-supply switch |
| standby | output | 1 | Standby state indicator |

## Verification
The hardest situation to reach is the exact boundary of the confirmation window. There, the low-load flag drops in the very cycle before or after the timer samples it, and the result hinges on the synchronizer delay plus the timer latency. The bench reaches it with a sweep. For each trial it resets the block and moves it into the running state with a short error pulse. It then holds the below-skip flag for a duration swept across the window, from a few ticks short to a few ticks long. For each duration it compares `standby` against the expected threshold. The standby trials then go on to ripple and exit stimulus.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_RUN   = 2'd1,
        ST_STBY  = 2'd2,
        ST_FAULT = 2'd3
    } sbm_state_e;

    localparam int FLAG_SKIP = 0;
    localparam int FLAG_EXIT = 1;
    localparam int FLAG_ERR  = 2;
    localparam int NFLAGS    = 3;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } sbm_edge_t;

    function automatic logic aux_on(input sbm_state_e st);
        return st == ST_RUN;
    endfunction

endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic s1, s2, prev;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1   <= 1'b0;
                    s2   <= 1'b0;
                    prev <= 1'b0;
                end else begin
                    s1   <= raw_i[g];
                    s2   <= s1;
                    prev <= s2;
                end
            end
            assign lvl_o[g]  = s2;
            assign rise_o[g] = s2 & ~prev;
            assign fall_o[g] = ~s2 & prev;
        end
    endgenerate
endmodule

// File: rtl/sbm_timer.sv
module sbm_timer #(
    parameter int TICKS = 12,
    localparam int CW = $clog2(TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          cancel_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst || cancel_i) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            cnt_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_o) begin
                busy_o <= 1'b1;
                cnt_o  <= '0;
            end else if (busy_o) begin
                if (cnt_o == LAST) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                    cnt_o  <= '0;
                end else begin
                    cnt_o <= cnt_o + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
    import sbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sbm_edge_t  skip_i,
    input  sbm_edge_t  exit_i,
    input  sbm_edge_t  err_i,
    input  logic       ll_done_i,
    input  logic       er_done_i,
    output sbm_state_e state_o,
    output logic       ll_start_o,
    output logic       ll_cancel_o,
    output logic       er_start_o,
    output logic       er_cancel_o
);
    sbm_state_e nxt;
    logic       err_timeout;

    assign err_timeout = er_done_i && err_i.lvl;

    always_comb begin
        nxt = state_o;
        unique case (state_o)
            ST_START: if (err_timeout) nxt = ST_FAULT;
                      else if (err_i.fall) nxt = ST_RUN;
            ST_RUN:   if (err_timeout) nxt = ST_FAULT;
                      else if (ll_done_i && skip_i.lvl) nxt = ST_STBY;
            ST_STBY:  if (err_timeout) nxt = ST_FAULT;
                      else if (exit_i.fall) nxt = ST_RUN;
            ST_FAULT: if (err_i.fall) nxt = ST_RUN;
            default:  nxt = ST_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_o <= ST_START;
        else     state_o <= nxt;
    end

    assign ll_start_o  = (state_o == ST_RUN) && skip_i.rise;
    assign ll_cancel_o = (state_o != ST_RUN);
    assign er_start_o  = err_i.rise;
    assign er_cancel_o = err_i.fall;
endmodule

// File: rtl/standby_event_mgr.sv
module standby_event_mgr
    import sbm_pkg::*;
#(
    parameter int CONFIRM_TICKS = 12_500_000,
    localparam int CW = $clog2(CONFIRM_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fb_below_skip,
    input  logic fb_below_exit,
    input  logic err_imax,
    output logic skip_req,
    output logic aux_en,
    output logic standby
);
    logic [NFLAGS-1:0] raw, lvl, rise, fall;
    sbm_edge_t         skip_e, exit_e, err_e;
    sbm_state_e        state;
    logic              ll_start, ll_cancel, ll_busy, ll_done;
    logic              er_start, er_cancel, er_busy, er_done;
    logic [CW-1:0]     ll_cnt, er_cnt;

    assign raw[FLAG_SKIP] = fb_below_skip;
    assign raw[FLAG_EXIT] = fb_below_exit;
    assign raw[FLAG_ERR]  = err_imax;

    sbm_sync #(.N(NFLAGS)) u_sync (
        .clk(clk), .rst(rst), .raw_i(raw),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    assign skip_e = '{lvl: lvl[FLAG_SKIP], rise: rise[FLAG_SKIP], fall: fall[FLAG_SKIP]};
    assign exit_e = '{lvl: lvl[FLAG_EXIT], rise: rise[FLAG_EXIT], fall: fall[FLAG_EXIT]};
    assign err_e  = '{lvl: lvl[FLAG_ERR],  rise: rise[FLAG_ERR],  fall: fall[FLAG_ERR]};

    sbm_timer #(.TICKS(CONFIRM_TICKS)) u_ll_tmr (
        .clk(clk), .rst(rst), .start_i(ll_start), .cancel_i(ll_cancel),
        .busy_o(ll_busy), .done_o(ll_done), .cnt_o(ll_cnt)
    );

    sbm_timer #(.TICKS(CONFIRM_TICKS)) u_er_tmr (
        .clk(clk), .rst(rst), .start_i(er_start), .cancel_i(er_cancel),
        .busy_o(er_busy), .done_o(er_done), .cnt_o(er_cnt)
    );

    sbm_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .skip_i(skip_e), .exit_i(exit_e), .err_i(err_e),
        .ll_done_i(ll_done), .er_done_i(er_done),
        .state_o(state),
        .ll_start_o(ll_start), .ll_cancel_o(ll_cancel),
        .er_start_o(er_start), .er_cancel_o(er_cancel)
    );

    assign skip_req = skip_e.lvl;
    assign aux_en   = aux_on(state);
    assign standby  = (state == ST_STBY);
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
    parameter int CONFIRM_TICKS = 12_500_000,
    localparam int CW = $clog2(CONFIRM_TICKS + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fb_below_skip,
    input logic          skip_req,
    input logic          aux_en,
    input logic          standby,
    input logic          skip_lvl,
    input logic          exit_fall,
    input logic          err_lvl,
    input logic          err_fall,
    input logic          ll_done,
    input logic          er_done,
    input logic [CW-1:0] ll_cnt,
    input logic [CW-1:0] er_cnt
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_skip_delay_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (skip_req == $past(fb_below_skip, 2)));

    assert_aux_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(aux_en) |-> ($past(err_fall) || $past(exit_fall)));

    assert_stby_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> $past(ll_done && skip_lvl));

    assert_stby_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (standby && !exit_fall && !(er_done && err_lvl)) |=> standby);

    assert_exit_now_R8: assert property (@(posedge clk) disable iff (rst)
        (standby && exit_fall && !(er_done && err_lvl)) |=> aux_en);

    assert_fault_off_R9: assert property (@(posedge clk) disable iff (rst)
        (er_done && err_lvl) |=> !aux_en);

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (ll_cnt < CW'(CONFIRM_TICKS)) && (er_cnt < CW'(CONFIRM_TICKS)));
endmodule

bind standby_event_mgr sbm_checker #(.CONFIRM_TICKS(CONFIRM_TICKS)) u_sbm_checker (
    .clk(clk), .rst(rst), .fb_below_skip(fb_below_skip),
    .skip_req(skip_req), .aux_en(aux_en), .standby(standby),
    .skip_lvl(skip_e.lvl), .exit_fall(exit_e.fall),
    .err_lvl(err_e.lvl), .err_fall(err_e.fall),
    .ll_done(ll_done), .er_done(er_done),
    .ll_cnt(ll_cnt), .er_cnt(er_cnt)
);

// File: tb/standby_event_mgr_bench.sv
module standby_event_mgr_bench;
    localparam int PERIOD = 10;
    localparam int TICKS  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic low = 1'b0, bexit = 1'b0, err = 1'b0;
    logic skip_req, aux_en, standby;
    int   total = 0, bad = 0;

    always #(PERIOD/2) clk = ~clk;

    standby_event_mgr #(.CONFIRM_TICKS(TICKS)) u_standby_event_mgr (
        .clk(clk), .rst(rst), .fb_below_skip(low), .fb_below_exit(bexit),
        .err_imax(err), .skip_req(skip_req), .aux_en(aux_en), .standby(standby)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        low = 0; bexit = 0; err = 0; rst = 1;
        step(3);
        rst = 0;
    endtask

    task automatic to_run();
        do_reset();
        err = 1; step(4);
        err = 0; step(4);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        low = 1; bexit = 1; err = 1;
        step(3);
        chk("R1 skip low in reset", skip_req, 1'b0);
        rst = 0; low = 0; bexit = 0; err = 0;
        step(3);
        chk("R2 aux after reset", aux_en, 1'b0);
        chk("R2 standby after reset", standby, 1'b0);
        chk("R2 skip after reset", skip_req, 1'b0);

        // R3: no error pulse keeps switch open
        do_reset(); step(3 * TICKS);
        chk("R3 aux idle startup", aux_en, 1'b0);
        // R3: short error pulse then exact closing edge
        do_reset(); err = 1; step(4); err = 0;
        step(2); chk("R3 aux before close", aux_en, 1'b0);
        step(1); chk("R3 aux closes", aux_en, 1'b1);

        // R1: skip_req delay of two edges
        low = 1; step(1); chk("R1 skip after 1 edge", skip_req, 1'b0);
        step(1); chk("R1 skip after 2 edges", skip_req, 1'b1);
        low = 0; step(2); chk("R1 skip released", skip_req, 1'b0);

        // R4: startup error outlasting window
        do_reset(); err = 1; step(TICKS + 6);
        chk("R4 aux startup fault", aux_en, 1'b0);
        err = 0; step(4);
        chk("R4 aux after fault clears", aux_en, 1'b1);

        // R5/R6 sweep across confirmation boundary, then R7/R8
        for (int d = TICKS - 3; d <= TICKS + 5; d++) begin
            logic exp_sb;
            exp_sb = (d >= TICKS + 2);
            to_run();
            low = 1; bexit = 1;
            step(d);
            low = 0;
            step(TICKS + 8);
            if (exp_sb) begin
                chk("R5 standby entered", standby, 1'b1);
                chk("R5 aux opened", aux_en, 1'b0);
                for (int k = 0; k < 6; k++) begin
                    low = ~low; step(3);
                    chk("R7 ripple standby", standby, 1'b1);
                    chk("R7 ripple aux", aux_en, 1'b0);
                end
                low = 0; bexit = 0;
                step(2); chk("R8 aux before exit", aux_en, 1'b0);
                step(1); chk("R8 aux immediate exit", aux_en, 1'b1);
                chk("R8 standby cleared", standby, 1'b0);
            end else begin
                chk("R6 stays running standby", standby, 1'b0);
                chk("R6 stays running aux", aux_en, 1'b1);
            end
        end

        // R9: error in running state
        to_run(); err = 1; step(TICKS + 6);
        chk("R9 aux fault running", aux_en, 1'b0);
        err = 0; step(4);
        chk("R9 aux recovered", aux_en, 1'b1);
        // R9/R10: short error under window leaves aux on
        err = 1; step(TICKS - 2); err = 0; step(6);
        chk("R10 short error below window", aux_en, 1'b1);

        // R9: error during standby
        to_run(); low = 1; bexit = 1; step(TICKS + 6);
        chk("R9 standby before error", standby, 1'b1);
        err = 1; step(TICKS + 6);
        chk("R9 fault from standby standby", standby, 1'b0);
        chk("R9 fault from standby aux", aux_en, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule